// File: doc/BRIEF.md
# Programmable Asynchronous Bus Cycle Generator

This block turns single host requests into read or write cycles on an external parallel bus with an 8-bit data path and a separate address path. Such a bus typically connects to a register file in an FPGA or a similar peripheral. The block drives four active-low strobes: chip select, address valid, output enable and write enable. Every strobe edge is placed at its own clock count, measured from the start of the cycle. Reads sample the data bus at a programmable access count, and each cycle ends at a programmable length. Reads and writes each hold their own full timing set, so each direction can be tuned to the peripheral on its own.

The host asks for a transfer by raising `req` together with direction, address and write data; the transfer is taken on a clock edge where `req` and `req_ready` are both high. `req_ready` is high while idle and also in the last counted clock of a running cycle, so a waiting request starts with no gap. The host sees a one-clock `ack` when the cycle ends, with the captured read byte on `ack_rdata`. Timing values are loaded one field at a time through a small configuration port, and only while the bus is quiet.

Top module: `abus_cycle_gen`

## Requirements
- R1: After reset, all four strobes are high, `bus_dq_oe` is 0, `ack` is 0 and `req_ready` is 1. The timing sets hold these values. Read set: chip select on 1 off 11, address valid on 1 off 3, output enable on 4 off 11, access 10, length 11. Write set: chip select on 1 off 5, address valid on 1 off 3, write enable on 1 off 5, access 0, length 5. Whenever no cycle runs, the strobes are high and `bus_dq_oe` is 0.
- R2: Count 0 is the clock after the accepting edge, and the count rises by one each clock. In a read, a strobe is low exactly in the counts c with on <= c < off_e, where off_e is the strobe's effective off count. Chip select and address valid use their own on/off pair. Output enable uses the direction pair, and write enable stays high. With the defaults, chip select is low for 10 clocks (counts 1..10).
- R3: `ack` is high for one clock at count L, where L is the effective length, and low in counts 0..L-1 unless a preceding cycle ends there. On a read, `ack_rdata` then holds the byte present on `bus_dq_i` during count A, where A is the effective access count.
- R4: A write follows the same strobe rule, but write enable takes the direction pair and output enable stays high. `bus_dq_oe` is 1 in counts 0..off_e-1 of the direction pair, and `bus_dq_o` shows the request's write data there. With the defaults, the cycle lasts 5 clocks.
- R5: During a read, `bus_dq_oe` stays 0 in every count.
- R6: If a strobe's off count is below its on count, or greater than L, its effective off count is L. A strobe whose effective off count is not above its on count never goes low.
- R7: `req_ready` is 1 in count L-1 and 0 in the earlier counts of a cycle. A request accepted there starts count 0 in the clock where `ack` of the ending cycle is high.
- R8: A high `cfg_wr` writes `cfg_value` into field `cfg_field` of the set `cfg_set` (0 read, 1 write). The field codes are 0 cs on, 1 cs off, 2 adv on, 3 adv off, 4 oe/we on, 5 oe/we off, 6 access, 7 length. The write is ignored while a cycle runs or while `req` is high.
- R9: `bus_addr` shows the request's address in every count of its cycle.
- R10: A length of 0 acts as 1. An access count of L or more acts as L-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Timing field write strobe |
| cfg_set | input | 1 | Timing set select, 0 read, 1 write |
| cfg_field | input | 3 | Timing field code |
| cfg_value | input | CNT_W (6) | Clock count to store |
| req | input | 1 | Transfer request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Transfer address |
| req_wdata | input | DATA_W | Write byte |
| req_ready | output | 1 | Request can be taken on this edge |
| ack | output | 1 | One-clock end-of-cycle pulse |
| ack_rdata | output | DATA_W | Captured read byte |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_adv_n | output | 1 | Address valid, active low |
| bus_oe_n | output | 1 | Output enable, active low |
| bus_we_n | output | 1 | Write enable, active low |
| bus_addr | output | ADDR_W | External address |
| bus_dq_o | output | DATA_W | Outgoing data |
| bus_dq_oe | output | 1 | Data drive enable, 0 means released |
| bus_dq_i | input | DATA_W | Incoming data |

## Verification
The hardest situation to reach is a chained transfer. There, the next request is taken in the last count of a running cycle, so the new count 0 shares its clock with the old `ack` while direction, address and data drive switch over. The bench reaches it by keeping `req` high with new fields from count 0 of the running cycle. It chains reads and writes both ways, including cycles of length one that end in every clock. Clamped edges are reached by reprogramming one strobe's on/off pair over a grid that includes reversed pairs and off counts past the cycle length. The bus is given a new byte in every count, so a capture one clock early or late is seen.

// File: rtl/abus_pkg.sv
`timescale 1ns/1ps
package abus_pkg;

    localparam int CNT_W   = 6;
    localparam int NUM_STB = 4;
    localparam int STB_CS  = 0;
    localparam int STB_ADV = 1;
    localparam int STB_OE  = 2;
    localparam int STB_WE  = 3;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [2:0] {
        FLD_CS_ON   = 3'd0,
        FLD_CS_OFF  = 3'd1,
        FLD_ADV_ON  = 3'd2,
        FLD_ADV_OFF = 3'd3,
        FLD_RW_ON   = 3'd4,
        FLD_RW_OFF  = 3'd5,
        FLD_ACCESS  = 3'd6,
        FLD_LENGTH  = 3'd7
    } fld_e;

    typedef struct packed {
        cnt_t cs_on;
        cnt_t cs_off;
        cnt_t adv_on;
        cnt_t adv_off;
        cnt_t rw_on;
        cnt_t rw_off;
        cnt_t access;
        cnt_t length;
    } tmg_t;

    function automatic tmg_t tmg_reset(input logic is_wr);
        tmg_t t;
        t.cs_on   = cnt_t'(1);
        t.adv_on  = cnt_t'(1);
        t.adv_off = cnt_t'(3);
        if (is_wr) begin
            t.cs_off = cnt_t'(5);
            t.rw_on  = cnt_t'(1);
            t.rw_off = cnt_t'(5);
            t.access = cnt_t'(0);
            t.length = cnt_t'(5);
        end else begin
            t.cs_off = cnt_t'(11);
            t.rw_on  = cnt_t'(4);
            t.rw_off = cnt_t'(11);
            t.access = cnt_t'(10);
            t.length = cnt_t'(11);
        end
        return t;
    endfunction

    function automatic tmg_t tmg_update(input tmg_t t, input fld_e f, input cnt_t v);
        tmg_t r;
        r = t;
        case (f)
            FLD_CS_ON:   r.cs_on   = v;
            FLD_CS_OFF:  r.cs_off  = v;
            FLD_ADV_ON:  r.adv_on  = v;
            FLD_ADV_OFF: r.adv_off = v;
            FLD_RW_ON:   r.rw_on   = v;
            FLD_RW_OFF:  r.rw_off  = v;
            FLD_ACCESS:  r.access  = v;
            default:     r.length  = v;
        endcase
        return r;
    endfunction

    // A zero length still occupies one clock.
    function automatic cnt_t eff_length(input cnt_t len);
        return (len == '0) ? cnt_t'(1) : len;
    endfunction

    // Reversed or overlong off counts fall back to the cycle end.
    function automatic cnt_t eff_off(input cnt_t on, input cnt_t off, input cnt_t len);
        return ((off < on) || (off > len)) ? len : off;
    endfunction

    function automatic cnt_t eff_access(input cnt_t acc, input cnt_t len);
        return (acc >= len) ? (len - cnt_t'(1)) : acc;
    endfunction

    function automatic logic in_window(input cnt_t k, input cnt_t on, input cnt_t off_e);
        return (k >= on) && (k < off_e);
    endfunction

endpackage

// File: rtl/abus_cfg.sv
`timescale 1ns/1ps
module abus_cfg
    import abus_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       lock,
    input  logic       cfg_wr,
    input  logic       cfg_set,
    input  fld_e       cfg_field,
    input  cnt_t       cfg_value,
    output tmg_t [1:0] tmg_q
);

    // Index 0 holds the read set, index 1 the write set.
    for (genvar g = 0; g < 2; g++) begin : g_set
        always_ff @(posedge clk) begin
            if (rst) begin
                tmg_q[g] <= tmg_reset(g == 1);
            end else if (cfg_wr && !lock && (cfg_set == (g == 1))) begin
                tmg_q[g] <= tmg_update(tmg_q[g], cfg_field, cfg_value);
            end
        end
    end

endmodule

// File: rtl/abus_seq.sv
`timescale 1ns/1ps
module abus_seq
    import abus_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req,
    input  logic       req_write,
    input  tmg_t [1:0] tmg_q,
    output logic       active_q,
    output logic       wr_q,
    output cnt_t       cnt_q,
    output logic       active_d,
    output logic       wr_d,
    output cnt_t       cnt_d,
    output logic       accept,
    output logic       req_ready,
    output logic       ack_q
);

    tmg_t cur_tmg;
    cnt_t cur_len;
    logic last;

    assign cur_tmg   = tmg_q[wr_q];
    assign cur_len   = eff_length(cur_tmg.length);
    assign last      = active_q && (cnt_q == cur_len - cnt_t'(1));
    assign req_ready = !active_q || last;
    assign accept    = req && req_ready;

    always_comb begin
        active_d = active_q;
        wr_d     = wr_q;
        cnt_d    = cnt_q;
        if (accept) begin
            active_d = 1'b1;
            wr_d     = req_write;
            cnt_d    = '0;
        end else if (last) begin
            active_d = 1'b0;
            cnt_d    = '0;
        end else if (active_q) begin
            cnt_d    = cnt_q + cnt_t'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            wr_q     <= 1'b0;
            cnt_q    <= '0;
            ack_q    <= 1'b0;
        end else begin
            active_q <= active_d;
            wr_q     <= wr_d;
            cnt_q    <= cnt_d;
            ack_q    <= last;
        end
    end

endmodule

// File: rtl/abus_strobe.sv
`timescale 1ns/1ps
module abus_strobe
    import abus_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic active_d,
    input  logic enable,
    input  cnt_t cnt_d,
    input  cnt_t on_cnt,
    input  cnt_t off_cnt,
    input  cnt_t len,
    output logic strobe_n
);

    // Registered from next-state so the pin changes cleanly on the edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_n <= 1'b1;
        end else begin
            strobe_n <= !(active_d && enable &&
                          in_window(cnt_d, on_cnt, eff_off(on_cnt, off_cnt, len)));
        end
    end

endmodule

// File: rtl/abus_cycle_gen.sv
`timescale 1ns/1ps
module abus_cycle_gen
    import abus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic              cfg_set,
    input  logic [2:0]        cfg_field,
    input  logic [CNT_W-1:0]  cfg_value,
    input  logic              req,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              ack,
    output logic [DATA_W-1:0] ack_rdata,
    output logic              bus_cs_n,
    output logic              bus_adv_n,
    output logic              bus_oe_n,
    output logic              bus_we_n,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_dq_o,
    output logic              bus_dq_oe,
    input  logic [DATA_W-1:0] bus_dq_i
);

    tmg_t [1:0] tmg_q;
    logic       active_q, wr_q, active_d, wr_d, accept;
    cnt_t       cnt_q, cnt_d;

    abus_cfg u_cfg (
        .clk       (clk),
        .rst       (rst),
        .lock      (active_q || req),
        .cfg_wr    (cfg_wr),
        .cfg_set   (cfg_set),
        .cfg_field (fld_e'(cfg_field)),
        .cfg_value (cfg_value),
        .tmg_q     (tmg_q)
    );

    abus_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .req_write (req_write),
        .tmg_q     (tmg_q),
        .active_q  (active_q),
        .wr_q      (wr_q),
        .cnt_q     (cnt_q),
        .active_d  (active_d),
        .wr_d      (wr_d),
        .cnt_d     (cnt_d),
        .accept    (accept),
        .req_ready (req_ready),
        .ack_q     (ack)
    );

    // Timing of the cycle that the next clock belongs to.
    tmg_t nx_tmg;
    cnt_t nx_len;
    assign nx_tmg = tmg_q[wr_d];
    assign nx_len = eff_length(nx_tmg.length);

    cnt_t stb_on  [NUM_STB];
    cnt_t stb_off [NUM_STB];
    logic stb_en  [NUM_STB];
    logic [NUM_STB-1:0] stb_n;

    always_comb begin
        stb_on[STB_CS]   = nx_tmg.cs_on;
        stb_off[STB_CS]  = nx_tmg.cs_off;
        stb_en[STB_CS]   = 1'b1;
        stb_on[STB_ADV]  = nx_tmg.adv_on;
        stb_off[STB_ADV] = nx_tmg.adv_off;
        stb_en[STB_ADV]  = 1'b1;
        stb_on[STB_OE]   = nx_tmg.rw_on;
        stb_off[STB_OE]  = nx_tmg.rw_off;
        stb_en[STB_OE]   = !wr_d;
        stb_on[STB_WE]   = nx_tmg.rw_on;
        stb_off[STB_WE]  = nx_tmg.rw_off;
        stb_en[STB_WE]   = wr_d;
    end

    for (genvar g = 0; g < NUM_STB; g++) begin : g_stb
        abus_strobe u_stb (
            .clk      (clk),
            .rst      (rst),
            .active_d (active_d),
            .enable   (stb_en[g]),
            .cnt_d    (cnt_d),
            .on_cnt   (stb_on[g]),
            .off_cnt  (stb_off[g]),
            .len      (nx_len),
            .strobe_n (stb_n[g])
        );
    end

    assign bus_cs_n  = stb_n[STB_CS];
    assign bus_adv_n = stb_n[STB_ADV];
    assign bus_oe_n  = stb_n[STB_OE];
    assign bus_we_n  = stb_n[STB_WE];

    // Capture point of the running cycle.
    tmg_t cur_tmg;
    cnt_t cur_acc;
    logic capture;
    assign cur_tmg = tmg_q[wr_q];
    assign cur_acc = eff_access(cur_tmg.access, eff_length(cur_tmg.length));
    assign capture = active_q && !wr_q && (cnt_q == cur_acc);

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q, rdata_q;
    logic              dq_oe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            dq_oe_q <= 1'b0;
        end else begin
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (capture) begin
                rdata_q <= bus_dq_i;
            end
            dq_oe_q <= active_d && wr_d &&
                       (cnt_d < eff_off(nx_tmg.rw_on, nx_tmg.rw_off, nx_len));
        end
    end

    assign bus_addr  = addr_q;
    assign bus_dq_o  = wdata_q;
    assign bus_dq_oe = dq_oe_q;
    assign ack_rdata = rdata_q;

endmodule

// File: rtl/abus_cycle_gen_chk.sv
`timescale 1ns/1ps
module abus_cycle_gen_chk
    import abus_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              active_q,
    input logic              wr_q,
    input cnt_t              cnt_q,
    input logic              req_ready,
    input logic              ack,
    input logic              bus_cs_n,
    input logic              bus_adv_n,
    input logic              bus_oe_n,
    input logic              bus_we_n,
    input logic              bus_dq_oe,
    input logic [ADDR_W-1:0] bus_addr,
    input tmg_t [1:0]        tmg_q
);

    AST_IDLE_REST: assert property (@(posedge clk) disable iff (rst)
        !active_q |-> (bus_cs_n && bus_adv_n && bus_oe_n && bus_we_n && !bus_dq_oe)); // R1

    AST_OE_WE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(!bus_oe_n && !bus_we_n)); // R2

    AST_ACK_AFTER_CYCLE: assert property (@(posedge clk) disable iff (rst)
        ack |-> $past(active_q)); // R3

    AST_WE_ONLY_WRITE: assert property (@(posedge clk) disable iff (rst)
        !bus_we_n |-> (active_q && wr_q)); // R4

    AST_READ_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (active_q && !wr_q) |-> !bus_dq_oe); // R5

    AST_READY_IDLE: assert property (@(posedge clk) disable iff (rst)
        !active_q |-> req_ready); // R7

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (active_q && $past(active_q)) |-> $stable(tmg_q)); // R8

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        (active_q && (cnt_q != '0)) |-> $stable(bus_addr)); // R9

endmodule

bind abus_cycle_gen abus_cycle_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .active_q  (active_q),
    .wr_q      (wr_q),
    .cnt_q     (cnt_q),
    .req_ready (req_ready),
    .ack       (ack),
    .bus_cs_n  (bus_cs_n),
    .bus_adv_n (bus_adv_n),
    .bus_oe_n  (bus_oe_n),
    .bus_we_n  (bus_we_n),
    .bus_dq_oe (bus_dq_oe),
    .bus_addr  (bus_addr),
    .tmg_q     (tmg_q)
);

// File: tb/abus_cycle_gen_tb.sv
`timescale 1ns/1ps
module abus_cycle_gen_tb;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_wr = 1'b0;
    logic              cfg_set = 1'b0;
    logic [2:0]        cfg_field = '0;
    logic [5:0]        cfg_value = '0;
    logic              req = 1'b0;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              req_ready, ack;
    logic [DATA_W-1:0] ack_rdata;
    logic              bus_cs_n, bus_adv_n, bus_oe_n, bus_we_n, bus_dq_oe;
    logic [ADDR_W-1:0] bus_addr;
    logic [DATA_W-1:0] bus_dq_o;
    logic [DATA_W-1:0] bus_dq_i = '0;

    always #4 clk = ~clk;

    abus_cycle_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_set(cfg_set),
        .cfg_field(cfg_field), .cfg_value(cfg_value), .req(req),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .ack(ack), .ack_rdata(ack_rdata),
        .bus_cs_n(bus_cs_n), .bus_adv_n(bus_adv_n), .bus_oe_n(bus_oe_n),
        .bus_we_n(bus_we_n), .bus_addr(bus_addr), .bus_dq_o(bus_dq_o),
        .bus_dq_oe(bus_dq_oe), .bus_dq_i(bus_dq_i)
    );

    int  checks = 0;
    int  errors = 0;
    int  salt   = 0;
    bit  done   = 0;
    int  mt [2][8];   // bench copy of the timing sets, field codes 0..7

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int elen(input int l);
        return (l == 0) ? 1 : l;
    endfunction

    function automatic int eoff(input int on, input int off, input int l);
        return ((off < on) || (off > l)) ? l : off;
    endfunction

    function automatic bit low(input int k, input int on, input int off, input int l);
        return (k >= on) && (k < eoff(on, off, l));
    endfunction

    function automatic int pat(input int k);
        return (k * 37 + salt * 11 + 5) & 255;
    endfunction

    task automatic cfgw(input int set, input int fld, input int val);
        cfg_wr = 1'b1; cfg_set = set[0]; cfg_field = fld[2:0]; cfg_value = val[5:0];
        @(negedge clk);
        cfg_wr = 1'b0;
        mt[set][fld] = val;
    endtask

    // Issue a request from idle; optional config write in the same clock (must be ignored).
    task automatic start(input bit wr, input int addr, input int wd, input bit poke);
        req = 1'b1; req_write = wr; req_addr = addr[ADDR_W-1:0]; req_wdata = wd[DATA_W-1:0];
        salt++;
        if (poke) begin
            cfg_wr = 1'b1; cfg_set = wr; cfg_field = 3'd1; cfg_value = 6'd2;
        end
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // Called at the negedge of count 0; returns at the negedge of count L.
    task automatic watch(input bit wr, input int addr, input int wd, input bit ack0,
                         input bit nx, input bit nwr, input int naddr, input int nwd,
                         input bit poke);
        int s, l, acc;
        bit [4:0] exp_v, act_v;
        s   = wr ? 1 : 0;
        l   = elen(mt[s][7]);
        acc = (mt[s][6] >= l) ? l - 1 : mt[s][6];
        for (int k = 0; k <= l; k++) begin
            if (k < l) begin
                exp_v[4] = !low(k, mt[s][0], mt[s][1], l);
                exp_v[3] = !low(k, mt[s][2], mt[s][3], l);
                exp_v[2] = wr ? 1'b1 : !low(k, mt[s][4], mt[s][5], l);
                exp_v[1] = wr ? !low(k, mt[s][4], mt[s][5], l) : 1'b1;
                exp_v[0] = wr && (k < eoff(mt[s][4], mt[s][5], l));
                act_v = {bus_cs_n, bus_adv_n, bus_oe_n, bus_we_n, bus_dq_oe};
                chk(act_v == exp_v, wr ? "R4/R6 strobes write" : "R2/R6 strobes read",
                    int'(act_v), int'(exp_v));
                if (!wr) chk(bus_dq_oe == 1'b0, "R5 bus released", int'(bus_dq_oe), 0);
                if (wr && exp_v[0]) chk(bus_dq_o == wd[DATA_W-1:0], "R4 write data",
                                        int'(bus_dq_o), wd & 255);
                chk(bus_addr == addr[ADDR_W-1:0], "R9 address", int'(bus_addr), addr);
                chk(req_ready == (k == l - 1), "R7 ready", int'(req_ready), int'(k == l - 1));
                chk(ack == (k == 0 && ack0), "R3 ack low in cycle", int'(ack), int'(k == 0 && ack0));
                bus_dq_i = pat(k);
                if (k == 0) begin
                    if (nx) begin
                        req = 1'b1; req_write = nwr;
                        req_addr = naddr[ADDR_W-1:0]; req_wdata = nwd[DATA_W-1:0];
                    end else begin
                        req = 1'b0;
                    end
                    if (poke) begin
                        cfg_wr = 1'b1; cfg_set = wr; cfg_field = 3'd7; cfg_value = 6'd3;
                    end
                end
                @(negedge clk);
                cfg_wr = 1'b0;
            end else begin
                chk(ack == 1'b1, "R3 ack at length", int'(ack), 1);
                if (!wr) chk(ack_rdata == pat(acc)[7:0], "R3/R10 captured byte",
                             int'(ack_rdata), pat(acc));
                if (!nx) begin
                    act_v = {bus_cs_n, bus_adv_n, bus_oe_n, bus_we_n, bus_dq_oe};
                    chk(act_v == 5'b11110, "R1 rest after cycle", int'(act_v), 30);
                end
            end
        end
        if (nx) salt++;
    endtask

    task automatic single(input bit wr, input int addr, input int wd);
        start(wr, addr, wd, 1'b0);
        watch(wr, addr, wd, 1'b0, 1'b0, 1'b0, 0, 0, 1'b0);
    endtask

    initial begin
        #800000;
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < 2; s++) begin
            mt[s][0] = 1; mt[s][2] = 1; mt[s][3] = 3;
        end
        mt[0][1] = 11; mt[0][4] = 4; mt[0][5] = 11; mt[0][6] = 10; mt[0][7] = 11;
        mt[1][1] = 5;  mt[1][4] = 1; mt[1][5] = 5;  mt[1][6] = 0;  mt[1][7] = 5;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk({bus_cs_n, bus_adv_n, bus_oe_n, bus_we_n} == 4'hF, "R1 strobes after reset",
            int'({bus_cs_n, bus_adv_n, bus_oe_n, bus_we_n}), 15);
        chk(bus_dq_oe == 1'b0, "R1 bus released after reset", int'(bus_dq_oe), 0);
        chk(ack == 1'b0, "R1 ack after reset", int'(ack), 0);
        chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);

        // Default timing sets (R1 values, R2 read, R4 write).
        single(1'b0, 16'h1234, 0);
        single(1'b1, 16'h0042, 8'hA5);

        // Chained transfers with no gap (R7).
        start(1'b0, 16'h0100, 0, 1'b0);
        watch(1'b0, 16'h0100, 0, 1'b0, 1'b1, 1'b1, 16'h0200, 8'h3C, 1'b0);
        watch(1'b1, 16'h0200, 8'h3C, 1'b1, 1'b1, 1'b0, 16'h0300, 0, 1'b0);
        watch(1'b0, 16'h0300, 0, 1'b1, 1'b0, 1'b0, 0, 0, 1'b0);

        // Config writes ignored while running or while req is high (R8).
        start(1'b0, 16'h0400, 0, 1'b0);
        watch(1'b0, 16'h0400, 0, 1'b0, 1'b0, 1'b0, 0, 0, 1'b1);
        start(1'b1, 16'h0401, 8'h77, 1'b1);
        watch(1'b1, 16'h0401, 8'h77, 1'b0, 1'b0, 1'b0, 0, 0, 1'b0);
        single(1'b0, 16'h0402, 0);

        // R6: chip-select window grid on a short read, including reversed and overlong offs.
        cfgw(0, 7, 5);
        cfgw(0, 6, 2);
        for (int on = 0; on < 4; on++) begin
            for (int off = 0; off < 8; off++) begin
                cfgw(0, 0, on);
                cfgw(0, 1, off);
                single(1'b0, 16'h1000 + on * 8 + off, 0);
            end
        end

        // R6/R4: write-enable and data-drive window grid on a 4-clock write.
        cfgw(1, 7, 4);
        for (int on = 0; on < 3; on++) begin
            for (int off = 0; off < 7; off++) begin
                cfgw(1, 4, on);
                cfgw(1, 5, off);
                single(1'b1, 16'h2000 + on * 8 + off, 16 + on * 8 + off);
            end
        end

        // R10: access beyond length clamps; zero length acts as one, chained back to back.
        cfgw(0, 6, 9);
        single(1'b0, 16'h3000, 0);
        cfgw(0, 7, 0);
        start(1'b0, 16'h3001, 0, 1'b0);
        watch(1'b0, 16'h3001, 0, 1'b0, 1'b1, 1'b0, 16'h3002, 0, 1'b0);
        watch(1'b0, 16'h3002, 0, 1'b1, 1'b1, 1'b1, 16'h3003, 8'h5A, 1'b0);
        watch(1'b1, 16'h3003, 8'h5A, 1'b1, 1'b0, 1'b0, 0, 0, 1'b0);

        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule